// File: doc/BRIEF.md
# Fractional M/N Clock Enable Generator with Programmable Duty

The block derives a slower clock enable from a reference clock. Over each window of N reference cycles it asserts its output in a pattern whose edge rate averages M/N of the reference. The share of the window spent high is set by a third value. The three settings arrive in encoded form. M is taken as written. The N field holds the bitwise inverse of (N − M). The D field holds the bitwise inverse of twice the wanted high count. All three are masked to `MND_W` bits. A two-bit mode field selects between the fractional pattern and a plain pass-through, in which the enable stays asserted on every reference cycle.

Inside the block, an accumulator adds M on every reference cycle, modulo N. The output is high while the accumulator value is below the decoded high count H. A separate window counter marks the N-cycle windows. A controller has three states:

- `ST_PASS`: pass-through, and every cycle counts as a window boundary.
- `ST_FRAC`: the fractional pattern is running.
- `ST_ARMED`: a new setting was committed in the middle of a window and is waiting.

The transitions are:

- `ST_PASS` → `ST_FRAC` when a commit loads a fractional setting.
- `ST_FRAC` → `ST_ARMED` when a commit arrives before the window's last cycle.
- `ST_FRAC`/`ST_ARMED` → `ST_FRAC` or `ST_PASS` at the last cycle of the window. A commit seen there, or one held from earlier, is loaded, and the new state follows the loaded setting.
- Otherwise the state is held.

Top module: `mnd_clk_gen`

## Requirements
- R1: After reset the block is in pass-through: `out_en_o` and `win_start_o` are 1 on every cycle until a commit is loaded.
- R2: A committed setting with `mode_i` = 0 gives pass-through (both outputs 1 every cycle), whatever the three codes hold.
- R3: N = (~`n_code_i` & mask) + M, with M = `m_code_i`. In fractional operation `win_start_o` is 1 in the first cycle of each N-cycle window and 0 in the other cycles.
- R4: In fractional operation, in cycle k after a load (k = 0 is the first cycle after the loading edge), `out_en_o` = ((k·M) mod N) < H.
- R5: The fractional pattern is used only when the mode is nonzero, N ≠ 0 and M ≠ N. A nonzero mode with M = N (`n_code_i` all ones) or with N = 0 gives pass-through.
- R6: H = round-half-up(D2 / 2), where D2 = ~`d_code_i` & mask. D2 is therefore saturated at the mask.
- R7: If the rounded value from R6 exceeds N − M, then H = N − M.
- R8: Otherwise, if floor(D2/2) < floor(M/2), then H = ceil(M/2).
- R9: When `m_code_i`, `n_code_i` and `d_code_i` are all zero, H = floor(N/2) and no clamp applies.
- R10: A D code equal to ~N & mask (for N ≤ mask) gives a high count of about half the window, H = ceil(N/2), subject to the clamps.
- R11: The codes and mode are ignored unless `commit_i` is 1. A commit made before the last cycle of a fractional window takes effect after that last cycle. If several commits arrive while waiting, the latest one wins. The codes present at the commit are the ones used, even if they change afterwards.
- R12: A load restarts both the accumulator and the window. The first cycle after a fractional load has `win_start_o` = 1 and the accumulator at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| commit_i | input | 1 | Strobe that captures the codes and the mode |
| mode_i | input | 2 | 0 = pass-through, nonzero = fractional |
| m_code_i | input | MND_W | M, stored as is |
| n_code_i | input | MND_W | Inverse of (N − M) |
| d_code_i | input | MND_W | Inverse of twice the high count |
| out_en_o | output | 1 | Generated clock enable |
| win_start_o | output | 1 | First cycle of an N-cycle window |

## Verification
With a 4-bit field width, every combination of the M, N and D codes is committed in a dual-edge mode. The output is compared cycle by cycle over a whole window against the accumulator formula. The D sweep separates the plain rounding path from the upper clamp, the lower clamp, the half-window code and the all-zero override. The N sweep covers the M = N and N = 0 bypass cases alongside coprime and non-coprime M/N pairs. The non-coprime pairs show whether the accumulator wraps modulo N or modulo a power of two. Directed sequences cover the following:

- a commit in the middle of a window, followed by code changes without a commit;
- two commits within one window;
- a mode-zero setting with nonzero codes.

Together these separate loading at the window boundary, loading at once, loading from the held copy and loading from the live inputs.

// File: rtl/mnd_gen_pkg.sv
package mnd_gen_pkg;

    typedef enum logic [1:0] {
        ST_PASS  = 2'd0,
        ST_FRAC  = 2'd1,
        ST_ARMED = 2'd2
    } gen_state_e;

    localparam logic [1:0] MODE_PASSTHRU = 2'd0;

endpackage

// File: rtl/mnd_decode.sv
module mnd_decode #(
    parameter int MND_W = 4
) (
    input  logic [1:0]       mode_i,
    input  logic [MND_W-1:0] m_code_i,
    input  logic [MND_W-1:0] n_code_i,
    input  logic [MND_W-1:0] d_code_i,
    output logic [MND_W-1:0] m_o,
    output logic [MND_W:0]   n_o,
    output logic [MND_W:0]   hi_o,
    output logic             frac_o
);
    import mnd_gen_pkg::*;

    localparam int CW = MND_W + 1;

    logic [MND_W-1:0] n_minus_m;
    logic [MND_W-1:0] dbl_hi;
    logic [CW-1:0]    hi_round;
    logic [CW-1:0]    hi_from_m;
    logic [CW-1:0]    n_full;
    logic             all_zero;
    logic             over_cap;
    logic             under_floor;

    always_comb begin
        n_minus_m   = ~n_code_i;
        dbl_hi      = ~d_code_i;
        n_full      = {1'b0, n_minus_m} + {1'b0, m_code_i};
        hi_round    = ({1'b0, dbl_hi} + CW'(1)) >> 1;
        hi_from_m   = ({1'b0, m_code_i} + CW'(1)) >> 1;
        all_zero    = (m_code_i == '0) && (n_code_i == '0) && (d_code_i == '0);
        over_cap    = hi_round > {1'b0, n_minus_m};
        under_floor = (dbl_hi >> 1) < (m_code_i >> 1);

        m_o    = m_code_i;
        n_o    = n_full;
        frac_o = (mode_i != MODE_PASSTHRU) && (n_full != '0)
                 && ({1'b0, m_code_i} != n_full);

        if (all_zero) begin
            hi_o = n_full >> 1;
        end else if (over_cap) begin
            hi_o = {1'b0, n_minus_m};
        end else if (under_floor) begin
            hi_o = hi_from_m;
        end else begin
            hi_o = hi_round;
        end
    end

endmodule

// File: rtl/mnd_ctrl.sv
module mnd_ctrl #(
    parameter int MND_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    commit_i,
    input  logic [MND_W-1:0]        dec_m_i,
    input  logic [MND_W:0]          dec_n_i,
    input  logic [MND_W:0]          dec_hi_i,
    input  logic                    dec_frac_i,
    input  logic                    win_end_i,
    output mnd_gen_pkg::gen_state_e state_o,
    output logic                    load_o,
    output logic [MND_W-1:0]        act_m_o,
    output logic [MND_W:0]          act_n_o,
    output logic [MND_W:0]          act_hi_o
);
    import mnd_gen_pkg::*;

    gen_state_e       state_q;
    gen_state_e       state_d;
    logic             apply;
    logic             hold_new;
    logic [MND_W-1:0] src_m;
    logic [MND_W:0]   src_n;
    logic [MND_W:0]   src_hi;
    logic             src_frac;
    logic [MND_W-1:0] sh_m;
    logic [MND_W:0]   sh_n;
    logic [MND_W:0]   sh_hi;
    logic             sh_frac;
    logic [MND_W-1:0] act_m;
    logic [MND_W:0]   act_n;
    logic [MND_W:0]   act_hi;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PASS;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and control outputs
    always_comb begin
        state_d  = state_q;
        apply    = 1'b0;
        hold_new = 1'b0;
        src_m    = commit_i ? dec_m_i    : sh_m;
        src_n    = commit_i ? dec_n_i    : sh_n;
        src_hi   = commit_i ? dec_hi_i   : sh_hi;
        src_frac = commit_i ? dec_frac_i : sh_frac;
        unique case (state_q)
            ST_PASS: begin
                if (commit_i) begin
                    apply   = 1'b1;
                    state_d = dec_frac_i ? ST_FRAC : ST_PASS;
                end
            end
            ST_FRAC: begin
                if (commit_i && win_end_i) begin
                    apply   = 1'b1;
                    state_d = dec_frac_i ? ST_FRAC : ST_PASS;
                end else if (commit_i) begin
                    hold_new = 1'b1;
                    state_d  = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (win_end_i) begin
                    apply   = 1'b1;
                    state_d = src_frac ? ST_FRAC : ST_PASS;
                end else if (commit_i) begin
                    hold_new = 1'b1;
                end
            end
            default: begin
                state_d = ST_PASS;
            end
        endcase
    end

    // held and active settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_m    <= '0;
            sh_n    <= '0;
            sh_hi   <= '0;
            sh_frac <= 1'b0;
            act_m   <= '0;
            act_n   <= '0;
            act_hi  <= '0;
        end else begin
            if (hold_new) begin
                sh_m    <= dec_m_i;
                sh_n    <= dec_n_i;
                sh_hi   <= dec_hi_i;
                sh_frac <= dec_frac_i;
            end
            if (apply) begin
                act_m  <= src_m;
                act_n  <= src_n;
                act_hi <= src_hi;
            end
        end
    end

    assign state_o  = state_q;
    assign load_o   = apply;
    assign act_m_o  = act_m;
    assign act_n_o  = act_n;
    assign act_hi_o = act_hi;

    AST_HOLD_WHILE_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && !win_end_i) |=> ($stable(act_m) && $stable(act_n) && $stable(act_hi))); // R11

    AST_HI_WITHIN_N: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_PASS) |-> (act_hi <= act_n)); // R7

endmodule

// File: rtl/mnd_accum.sv
module mnd_accum #(
    parameter int MND_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             load_i,
    input  logic [MND_W-1:0] m_i,
    input  logic [MND_W:0]   n_i,
    input  logic [MND_W:0]   hi_i,
    output logic             out_en_o,
    output logic             win_start_o,
    output logic             win_end_o
);
    localparam int CW = MND_W + 1;
    localparam int SW = MND_W + 2;

    logic [CW-1:0] acc_q;
    logic [CW-1:0] wcnt_q;
    logic [SW-1:0] acc_sum;
    logic [CW-1:0] acc_next;
    logic          last_cyc;

    always_comb begin
        acc_sum  = {1'b0, acc_q} + SW'(m_i);
        acc_next = (acc_sum >= {1'b0, n_i}) ? CW'(acc_sum - {1'b0, n_i}) : acc_sum[CW-1:0];
        last_cyc = (wcnt_q == n_i - CW'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            wcnt_q <= '0;
        end else if (load_i) begin
            acc_q  <= '0;
            wcnt_q <= '0;
        end else if (run_i) begin
            acc_q  <= acc_next;
            wcnt_q <= last_cyc ? '0 : wcnt_q + CW'(1);
        end
    end

    assign out_en_o    = !run_i || (acc_q < hi_i);
    assign win_start_o = !run_i || (wcnt_q == '0);
    assign win_end_o   = !run_i || last_cyc;

    AST_ACC_BELOW_N: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (acc_q < n_i)); // R4

    AST_WINDOW_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !load_i && last_cyc) |=> (wcnt_q == '0)); // R3

endmodule

// File: rtl/mnd_clk_gen.sv
module mnd_clk_gen #(
    parameter int MND_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit_i,
    input  logic [1:0]       mode_i,
    input  logic [MND_W-1:0] m_code_i,
    input  logic [MND_W-1:0] n_code_i,
    input  logic [MND_W-1:0] d_code_i,
    output logic             out_en_o,
    output logic             win_start_o
);
    import mnd_gen_pkg::*;

    logic [MND_W-1:0] dec_m;
    logic [MND_W:0]   dec_n;
    logic [MND_W:0]   dec_hi;
    logic             dec_frac;
    logic [MND_W-1:0] act_m;
    logic [MND_W:0]   act_n;
    logic [MND_W:0]   act_hi;
    logic             load;
    logic             win_end;
    logic             run;
    gen_state_e       state;

    mnd_decode #(.MND_W(MND_W)) u_decode (
        .mode_i   (mode_i),
        .m_code_i (m_code_i),
        .n_code_i (n_code_i),
        .d_code_i (d_code_i),
        .m_o      (dec_m),
        .n_o      (dec_n),
        .hi_o     (dec_hi),
        .frac_o   (dec_frac)
    );

    mnd_ctrl #(.MND_W(MND_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_i   (commit_i),
        .dec_m_i    (dec_m),
        .dec_n_i    (dec_n),
        .dec_hi_i   (dec_hi),
        .dec_frac_i (dec_frac),
        .win_end_i  (win_end),
        .state_o    (state),
        .load_o     (load),
        .act_m_o    (act_m),
        .act_n_o    (act_n),
        .act_hi_o   (act_hi)
    );

    assign run = (state != ST_PASS);

    mnd_accum #(.MND_W(MND_W)) u_accum (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run),
        .load_i      (load),
        .m_i         (act_m),
        .n_i         (act_n),
        .hi_i        (act_hi),
        .out_en_o    (out_en_o),
        .win_start_o (win_start_o),
        .win_end_o   (win_end)
    );

    AST_LOAD_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> win_start_o); // R12

endmodule

// File: tb/test_mnd_clk_gen.sv
module test_mnd_clk_gen;

    localparam int W    = 4;
    localparam int MASK = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         commit = 1'b0;
    logic [1:0]   mode = 2'd0;
    logic [W-1:0] mc = '0;
    logic [W-1:0] nc = '0;
    logic [W-1:0] dc = '0;
    logic         out_en;
    logic         win_start;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    mnd_clk_gen #(.MND_W(W)) i_mnd_clk_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit_i    (commit),
        .mode_i      (mode),
        .m_code_i    (mc),
        .n_code_i    (nc),
        .d_code_i    (dc),
        .out_en_o    (out_en),
        .win_start_o (win_start)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // arithmetic model of R2..R10
    task automatic model(input int m_c, input int n_c, input int d_c, input int md,
                         output int m, output int n, output int hi,
                         output bit frac, output string tag);
        int nm;
        int d2;
        int hr;
        m    = m_c;
        nm   = (~n_c) & MASK;
        n    = nm + m;
        d2   = (~d_c) & MASK;
        frac = (md != 0) && (n != 0) && (m != n);
        if (m_c == 0 && n_c == 0 && d_c == 0) begin
            hi = n / 2; tag = "R9";
        end else begin
            hr = (d2 + 1) / 2;
            if (hr > nm) begin
                hi = nm; tag = "R7";
            end else if ((d2 / 2) < (m / 2)) begin
                hi = (m + 1) / 2; tag = "R8";
            end else begin
                hi  = hr;
                tag = (n <= MASK && d_c == ((~n) & MASK)) ? "R10" : "R6";
            end
        end
        if (!frac) tag = (md == 0) ? "R2" : "R5";
    endtask

    task automatic drive(input int m_c, input int n_c, input int d_c, input int md, input bit cm);
        mc = W'(m_c); nc = W'(n_c); dc = W'(d_c); mode = 2'(md); commit = cm;
    endtask

    // called at a negedge; returns at the negedge of cycle 0 of the new setting
    task automatic load(input int m_c, input int n_c, input int d_c, input int md);
        drive(m_c, n_c, d_c, md, 1'b1);
        @(posedge clk);
        @(negedge clk);
        commit = 1'b0;
    endtask

    // checks cycles k0..k1 of a loaded setting; ends at the negedge of cycle k1
    task automatic check_run(input int m_c, input int n_c, input int d_c, input int md,
                             input int k0, input int k1);
        int m, n, hi;
        bit frac;
        string tag;
        int e_out, e_ws;
        model(m_c, n_c, d_c, md, m, n, hi, frac, tag);
        for (int k = k0; k <= k1; k++) begin
            e_out = frac ? ((((k * m) % n) < hi) ? 1 : 0) : 1;
            e_ws  = frac ? ((k == 0) ? 1 : 0) : 1;
            check(out_en == e_out, frac ? {"R4/", tag} : tag, out_en, e_out);
            check(win_start == e_ws, (k == 0) ? "R12" : "R3", win_start, e_ws);
            if (k < k1) @(negedge clk);
        end
    endtask

    function automatic int win_len(input int m_c, input int n_c, input int md);
        int n;
        n = ((~n_c) & MASK) + m_c;
        return (md != 0 && n != 0 && m_c != n) ? n : 2;
    endfunction

    initial begin
        #1_900_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        drive(3, 8, 5, 2, 1'b0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R11: pass-through after reset, codes without commit ignored
        for (int i = 0; i < 4; i++) begin
            check(out_en == 1'b1, "R1", out_en, 1);
            check(win_start == 1'b1, "R1", win_start, 1);
            drive(i, 8 - i, 5 + i, 2, 1'b0);
            @(negedge clk);
        end

        // R2: mode zero with nonzero codes
        load(3, 8, 5, 0);
        check_run(3, 8, 5, 0, 0, 3);

        // R11: commit mid-window, codes changed afterwards without commit
        load(3, 8, 5, 2);                 // N = 10, H = 5
        check_run(3, 8, 5, 2, 0, 3);
        drive(1, 11, 10, 2, 1'b1);        // N = 5, H = 3
        @(negedge clk);
        drive(7, 2, 1, 1, 1'b0);
        check_run(3, 8, 5, 2, 4, 9);      // R11: old window completes
        @(negedge clk);
        check_run(1, 11, 10, 2, 0, 4);    // R11: committed codes take effect

        // R11: latest of two commits in one window wins
        load(3, 8, 5, 2);
        check_run(3, 8, 5, 2, 0, 2);
        drive(1, 11, 10, 2, 1'b1);
        @(negedge clk);
        drive(0, 0, 0, 0, 1'b0);
        check_run(3, 8, 5, 2, 3, 5);
        drive(1, 13, 12, 2, 1'b1);        // N = 3, H = 2
        @(negedge clk);
        drive(0, 0, 0, 0, 1'b0);
        check_run(3, 8, 5, 2, 6, 9);
        @(negedge clk);
        check_run(1, 13, 12, 2, 0, 2);    // R11: latest commit

        // R3..R10: exhaustive sweep of codes in dual-edge mode
        for (int a = 0; a <= MASK; a++) begin
            for (int b = 0; b <= MASK; b++) begin
                for (int c = 0; c <= MASK; c++) begin
                    load(a, b, c, 2);
                    check_run(a, b, c, 2, 0, win_len(a, b, 2) - 1);
                end
            end
        end

        // R5: explicit bypass cases
        load(5, MASK, 3, 2);
        check_run(5, MASK, 3, 2, 0, 3);
        load(0, MASK, 3, 1);
        check_run(0, MASK, 3, 1, 0, 3);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule